// File: doc/BRIEF.md
# Dual-Mode Interval and Compare Timer Channel

This block is one timer channel behind a simple single-cycle register port. It runs in one of two modes, chosen when it starts. In interval mode the counter is loaded with the compare value and counts down on every count-clock enable. When it passes zero it reloads and raises a one-cycle interrupt, so a compare value of N−1 gives an interrupt every N enables. In free-running mode the counter is cleared at start and counts up, wrapping at 2^CNT_W. It raises a one-cycle interrupt each time the count matches the compare value. This mode serves as a monotonic time base, or as a one-shot delay if software stops the channel in its interrupt handler.

Starting and stopping are done by writing 1 to bit 0 of two separate write-only trigger registers. A read-only status register shows whether the channel is running. Writes to the compare value and the mode bit always update the registers that software reads back. The counter logic copies them only when the channel starts, so writes made while it runs wait for the next start.

The controller has three states. `ST_STOPPED` moves to `ST_INTERVAL` or to `ST_FREERUN` on a start trigger, and the mode bit picks which one. The state taken is called the start transition. Either running state returns to `ST_STOPPED` on a stop trigger, called the stop transition. A start trigger in a running state is ignored.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the channel is stopped, irq is low, and the compare, counter, status and control registers all read 0.
- R2: Register map, by byte address: compare at 0x00 (read/write), counter at 0x04 (read-only), run status at 0x10 (bit 0, read-only), start trigger at 0x14 and stop trigger at 0x18 (write-only, bit 0), control at 0x20 (bit 1 = mode: 0 interval, 1 free-running). Unmapped or misaligned addresses read 0.
- R3: Writing the start trigger with byte strobe 0 set and data bit 0 = 1 while stopped makes the status read 1 in the next cycle. The counter is loaded with the compare value in interval mode and with 0 in free-running mode.
- R4: Writing the stop trigger with bit 0 = 1 while running makes the status read 0 in the next cycle. The counter then keeps its value, and count enables no longer change it.
- R5: A trigger write with data bit 0 = 0 or with byte strobe 0 clear has no effect. A start trigger while running neither reloads nor clears the counter.
- R6: In interval mode each count enable decrements the counter. A count enable at 0 reloads the compare value and raises irq for exactly the next cycle, giving a period of compare+1 enables.
- R7: In free-running mode each count enable increments the counter, wrapping from all ones to 0. A count enable while the counter equals the compare value raises irq for the next cycle. This includes an all-ones compare value.
- R8: Compare and control writes made while running read back at once. The running count keeps using the values captured at start, and the new ones apply from the next start.
- R9: Compare writes update only byte lanes whose strobe is set. Bits at or above CNT_W are not stored and read 0.
- R10: Both trigger addresses read 0. The control register stores only bit 1, and its other bits read 0.
- R11: Without a count enable the counter keeps its value.
- R12: irq is high only in the cycle after a count enable that the running channel received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cnt_tick | input | 1 | Count-clock enable |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with CNT_W = 8, not the default 32. With that width, a full counter wrap and an all-ones compare value take only 256 count enables, so both the wrap to zero and the match at the largest compare value are exercised. The narrow width also puts the compare register's upper byte lanes above the counter width, which tests that those lanes are dropped. Interval periods and free-running match points use small compare values, so the exact count-enable index of each interrupt can be checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_INTERVAL = 2'd1,
        ST_FREERUN  = 2'd2
    } tmr_state_e;

    // byte offsets; software depends on them
    localparam logic [7:0] OFS_CMP   = 8'h00;
    localparam logic [7:0] OFS_CNT   = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_START = 8'h14;
    localparam logic [7:0] OFS_STOP  = 8'h18;
    localparam logic [7:0] OFS_CTRL  = 8'h20;

    localparam int MODE_BIT = 1;
    localparam int BUS_W    = 32;
    localparam int LANES    = BUS_W / 8;
endpackage

// File: rtl/timer_regfile.sv
module timer_regfile
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              running,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              mode_free,
    output logic              start_req,
    output logic              stop_req
);
    logic [CNT_W-1:0] cmp_q;
    logic             mode_q;
    logic [BUS_W-1:0] cmp_ext, cmp_merge;
    logic             sel_cmp, sel_ctrl;

    assign cmp_ext = BUS_W'(cmp_q);

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign cmp_merge[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : cmp_ext[8*b +: 8];
        end
    endgenerate

    always_comb begin
        sel_cmp   = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));
        sel_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_be[0];
        start_req = bus_wr && (bus_addr == ADDR_W'(OFS_START)) && bus_be[0] && bus_wdata[0];
        stop_req  = bus_wr && (bus_addr == ADDR_W'(OFS_STOP)) && bus_be[0] && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            if (sel_cmp)  cmp_q  <= cmp_merge[CNT_W-1:0];
            if (sel_ctrl) mode_q <= bus_wdata[MODE_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CMP))       bus_rdata = cmp_ext;
        else if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata = BUS_W'(cnt_val);
        else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = BUS_W'(running);
        else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata[MODE_BIT] = mode_q;
    end

    assign cmp_val   = cmp_q;
    assign mode_free = mode_q;

    // R8
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_cmp |=> $stable(cmp_q));
endmodule

// File: rtl/timer_fsm.sv
module timer_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic mode_free,
    output logic running,
    output logic run_free,
    output logic load
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (start_req) state_d = mode_free ? ST_FREERUN : ST_INTERVAL;
            ST_INTERVAL: if (stop_req)  state_d = ST_STOPPED;
            ST_FREERUN:  if (stop_req)  state_d = ST_STOPPED;
            default:                    state_d = ST_STOPPED;
        endcase
    end

    always_comb begin
        running  = (state_q != ST_STOPPED);
        run_free = (state_q == ST_FREERUN);
        load     = (state_q == ST_STOPPED) && start_req;
    end

    // R3
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running);
    // R4
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_req) |=> !running);
    // R5
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop_req) |=> (running && $stable(run_free)));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             load_free,
    input  logic             run,
    input  logic             run_free,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q, act_cmp_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_cmp_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (load) begin
                act_cmp_q <= cmp_val;
                cnt_q     <= load_free ? '0 : cmp_val;
            end else if (run && tick) begin
                if (run_free) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    irq_q <= (cnt_q == act_cmp_q);
                end else if (cnt_q == '0) begin
                    cnt_q <= act_cmp_q;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
    // R12
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(run && tick));
    // R6
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !run_free && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R7
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_free && tick && !load && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cnt_tick,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_val, cmp_val;
    logic mode_free, start_req, stop_req, running, run_free, load;

    timer_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .running(running), .cmp_val(cmp_val),
        .mode_free(mode_free), .start_req(start_req), .stop_req(stop_req)
    );

    timer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .mode_free(mode_free), .running(running), .run_free(run_free), .load(load)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .load(load),
        .load_free(mode_free), .run(running), .run_free(run_free),
        .cmp_val(cmp_val), .cnt(cnt_val), .irq(irq)
    );
endmodule

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;
    localparam int CNT_W = 8;
    localparam int ADDR_W = 6;
    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10,
                           A_START = 6'h14, A_STOP = 6'h18, A_CTRL = 6'h20;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, cnt_tick = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    dual_mode_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick1();
        @(negedge clk); cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CMP, d);  chk("R1 compare", d, 0);
        rd(A_CNT, d);  chk("R1 counter", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_CTRL, d); chk("R1 control", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_interval();
        logic [31:0] d;
        wr(A_CTRL, 4'hF, 0);
        wr(A_CMP, 4'hF, 4);
        wr(A_START, 4'h1, 1);
        rd(A_STAT, d); chk("R3 status after start", d, 1);
        rd(A_CNT, d);  chk("R3 interval load", d, 4);
        for (int i = 1; i <= 10; i++) begin
            tick1();
            chk("R6 interval irq", {31'b0, irq}, (i % 5 == 0) ? 1 : 0);
        end
        rd(A_CNT, d); chk("R6 reload", d, 4);
        @(negedge clk); chk("R6 one-cycle pulse", {31'b0, irq}, 0);
        wr(A_STOP, 4'h1, 1);
        rd(A_STAT, d); chk("R4 status after stop", d, 0);
        tick1(); tick1(); tick1();
        rd(A_CNT, d); chk("R4 counter held", d, 4);
        chk("R12 irq stopped", {31'b0, irq}, 0);
    endtask

    task automatic t_freerun();
        logic [31:0] d;
        wr(A_CTRL, 4'h1, 2);
        wr(A_CMP, 4'hF, 3);
        wr(A_START, 4'h1, 1);
        rd(A_CNT, d); chk("R3 freerun clear", d, 0);
        for (int i = 1; i <= 6; i++) begin
            tick1();
            chk("R7 match irq", {31'b0, irq}, (i == 4) ? 1 : 0);
        end
        rd(A_CNT, d); chk("R7 upcount", d, 6);
        wr(A_STOP, 4'h1, 1);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        int hits = 0, last = 0;
        wr(A_CMP, 4'hF, 32'hFF);
        wr(A_START, 4'h1, 1);
        for (int i = 1; i <= 256; i++) begin
            tick1();
            if (irq) begin hits++; last = i; end
        end
        chk("R7 all-ones irq count", hits, 1);
        chk("R7 all-ones irq index", last, 256);
        rd(A_CNT, d); chk("R7 wrap to zero", d, 0);
        wr(A_STOP, 4'h1, 1);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(A_START, 4'h1, 0);
        rd(A_STAT, d); chk("R5 start data0", d, 0);
        wr(A_START, 4'h0, 1);
        rd(A_STAT, d); chk("R5 start no strobe", d, 0);
        wr(A_CTRL, 4'h1, 0);
        wr(A_CMP, 4'hF, 7);
        wr(A_START, 4'h1, 1);
        tick1(); tick1();
        rd(A_CNT, d); chk("R5 pre-restart count", d, 5);
        wr(A_START, 4'h1, 1);
        rd(A_CNT, d); chk("R5 restart ignored", d, 5);
        wr(A_STOP, 4'h1, 0);
        rd(A_STAT, d); chk("R5 stop data0", d, 1);
        wr(A_STOP, 4'h0, 1);
        rd(A_STAT, d); chk("R5 stop no strobe", d, 1);
        wr(A_STOP, 4'h1, 1);
    endtask

    task automatic t_shadow();
        logic [31:0] d;
        wr(A_CTRL, 4'h1, 0);
        wr(A_CMP, 4'hF, 2);
        wr(A_START, 4'h1, 1);
        wr(A_CMP, 4'hF, 9);
        wr(A_CTRL, 4'h1, 2);
        rd(A_CMP, d);  chk("R8 compare readback", d, 9);
        rd(A_CTRL, d); chk("R8 control readback", d, 2);
        for (int i = 1; i <= 3; i++) begin
            tick1();
            chk("R8 old period kept", {31'b0, irq}, (i == 3) ? 1 : 0);
        end
        rd(A_CNT, d); chk("R8 old reload", d, 2);
        wr(A_STOP, 4'h1, 1);
        wr(A_START, 4'h1, 1);
        rd(A_CNT, d); chk("R8 new mode at start", d, 0);
        tick1();
        rd(A_CNT, d); chk("R8 new mode counts up", d, 1);
        wr(A_STOP, 4'h1, 1);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        wr(A_CMP, 4'h1, 32'h1234_56AB);
        rd(A_CMP, d); chk("R9 lane0 write", d, 32'hAB);
        wr(A_CMP, 4'hE, 32'hFFFF_FF00);
        rd(A_CMP, d); chk("R9 upper lanes dropped", d, 32'hAB);
        wr(A_CMP, 4'h0, 32'h55);
        rd(A_CMP, d); chk("R9 no strobe", d, 32'hAB);
    endtask

    task automatic t_readmap();
        logic [31:0] d;
        rd(A_START, d); chk("R10 start reads 0", d, 0);
        rd(A_STOP, d);  chk("R10 stop reads 0", d, 0);
        rd(6'h0C, d);   chk("R2 unmapped reads 0", d, 0);
        rd(6'h01, d);   chk("R2 misaligned reads 0", d, 0);
        wr(A_CTRL, 4'hF, 32'hFF);
        rd(A_CTRL, d);  chk("R10 control bit1 only", d, 2);
        wr(A_CTRL, 4'h1, 0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        wr(A_CMP, 4'hF, 7);
        wr(A_START, 4'h1, 1);
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R11 no tick hold", d, 7);
        chk("R12 no irq without tick", {31'b0, irq}, 0);
        wr(A_STOP, 4'h1, 1);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_interval();
        t_freerun();
        t_wrap();
        t_ignored();
        t_shadow();
        t_bytes();
        t_readmap();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule